// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block decides, every clock, which hardware thread context feeds the next instruction into a pipeline that several threads share. It sees one ready flag and one stall flag per thread. It also sees a long-stall event, a mode select and an optional preferred-thread setting. From these it produces a thread number, an issue-valid flag and a flush request. It supports up to four threads.

The block has two modes. In interleaved (fine) mode the chosen thread may change on every cycle. Selection rotates through the threads and passes over any thread that cannot issue. A preferred thread, when one is enabled, takes the slot whenever it is able to issue. In switch-on-stall (coarse) mode one owner thread keeps the pipeline. Control moves to another thread only when the owner reports a costly stall, such as a second-level cache miss. At that point the block raises a flush request. It then holds off valid issue for a fixed number of refill cycles, which models the start-up of the pipeline.

Top module: `mt_issue_sel`

## Requirements
- R1: After reset the selector is in its initial state: owner thread 0, rotation pointer 0 and no refill pending. With every thread eligible and fine mode selected (`mode_coarse`=0), the first issue goes to thread 0.
- R2: A thread is eligible when its ready bit is 1 and its stall bit is 0. In fine mode with no preferred thread eligible, the block issues the first eligible thread, searching upward from the rotation pointer and wrapping from the top thread to thread 0. Valid is 1 in that cycle.
- R3: Each valid issue in fine mode sets the rotation pointer to the issued thread plus one, modulo the thread count. A thread that was passed over therefore comes before the issuing thread in the next search.
- R4: When no thread is eligible, valid is 0 and the rotation pointer keeps its value.
- R5: In fine mode, when `pref_en`=1 and thread `pref_tid` is eligible, that thread is issued whatever the value of the pointer.
- R6: In coarse mode the output thread is the current owner. Valid is 1 exactly when the owner is eligible, no long stall is signalled and no refill is pending. The owner does not change without a long stall.
- R7: In coarse mode, a long stall with some other thread eligible causes a switch, with valid 0 in that cycle. The new owner is the preferred thread if it is enabled, eligible and not the owner. Otherwise it is the first eligible thread above the owner, in cyclic order. `flush_req` is 1 in the cycle of the long stall.
- R8: After a switch, valid stays 0 for REFILL_CYCLES cycles in both modes. It may become 1 on the cycle after that.
- R9: A long stall in coarse mode with no other eligible thread causes no flush and leaves the owner unchanged.
- R10: In fine mode the long-stall input is ignored: `flush_req` stays 0 and selection follows R2 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_ready | input | NUM_THREADS | Per-thread has-instruction flag |
| thr_stall | input | NUM_THREADS | Per-thread stalled flag |
| long_stall | input | 1 | Owner suffered a costly stall (coarse mode) |
| mode_coarse | input | 1 | 0 = fine interleave, 1 = switch on long stall |
| pref_en | input | 1 | Enable the preferred-thread override |
| pref_tid | input | TID_W | Preferred thread number |
| issue_tid | output | TID_W | Selected thread |
| issue_valid | output | 1 | An instruction of issue_tid is issued this cycle |
| flush_req | output | 1 | Empty the pipeline for a coarse switch |

## Verification
The bench builds the block with NUM_THREADS=4 and REFILL_CYCLES=3. Four threads make the wrap from thread 3 to thread 0, and searches that pass over several stalled threads, appear often under random eligibility. A three-cycle refill is short enough that random phases switch often. It is also long enough that back-to-back long stalls during a refill, and mode changes part-way through a refill, both occur.

// File: rtl/mts_pkg.sv
package mts_pkg;

    localparam int MAX_THREADS = 4;

    typedef enum logic {
        SEL_FINE   = 1'b0,
        SEL_COARSE = 1'b1
    } sel_mode_e;

    function automatic int wrap_inc(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/mts_rr_pick.sv
module mts_rr_pick #(
    parameter int N     = 4,
    parameter int TID_W = 2
) (
    input  logic [N-1:0]     elig,
    input  logic [TID_W-1:0] start,
    output logic             found,
    output logic [TID_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            int cand;
            cand = (int'(start) + k) % N;
            if (!found && elig[cand]) begin
                found = 1'b1;
                idx   = TID_W'(cand);
            end
        end
    end
endmodule

// File: rtl/mts_refill_ctr.sv
module mts_refill_ctr #(
    parameter int REFILL = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = (REFILL > 0) ? $clog2(REFILL + 1) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= CNT_W'(REFILL);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/mt_issue_sel.sv
module mt_issue_sel
    import mts_pkg::*;
#(
    parameter int NUM_THREADS   = 4,
    parameter int REFILL_CYCLES = 3,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_THREADS-1:0] thr_ready,
    input  logic [NUM_THREADS-1:0] thr_stall,
    input  logic                   long_stall,
    input  logic                   mode_coarse,
    input  logic                   pref_en,
    input  logic [TID_W-1:0]       pref_tid,
    output logic [TID_W-1:0]       issue_tid,
    output logic                   issue_valid,
    output logic                   flush_req
);
    sel_mode_e              mode;
    logic [NUM_THREADS-1:0] elig, others;
    logic [TID_W-1:0]       rr_ptr, owner, owner_nx;
    logic [TID_W-1:0]       fine_idx, next_idx, sw_tid;
    logic                   fine_found, next_found;
    logic                   pref_ok, pref_sw, sw_found, busy;

    assign mode = sel_mode_e'(mode_coarse);
    assign elig = thr_ready & ~thr_stall;

    always_comb begin
        others = elig;
        others[owner] = 1'b0;
    end

    assign owner_nx = TID_W'(wrap_inc(int'(owner), NUM_THREADS));
    assign pref_ok  = pref_en && (int'(pref_tid) < NUM_THREADS) && elig[pref_tid];
    assign pref_sw  = pref_ok && (pref_tid != owner);

    mts_rr_pick #(.N(NUM_THREADS), .TID_W(TID_W)) u_fine_pick (
        .elig(elig), .start(rr_ptr), .found(fine_found), .idx(fine_idx)
    );

    mts_rr_pick #(.N(NUM_THREADS), .TID_W(TID_W)) u_next_pick (
        .elig(others), .start(owner_nx), .found(next_found), .idx(next_idx)
    );

    assign sw_found = pref_sw || next_found;
    assign sw_tid   = pref_sw ? pref_tid : next_idx;

    mts_refill_ctr #(.REFILL(REFILL_CYCLES)) u_refill (
        .clk(clk), .rst(rst), .load(flush_req), .busy(busy)
    );

    always_comb begin
        if (mode == SEL_COARSE) begin
            issue_tid   = owner;
            issue_valid = elig[owner] && !long_stall && !busy;
            flush_req   = long_stall && sw_found;
        end else begin
            issue_tid   = pref_ok ? pref_tid : fine_idx;
            issue_valid = (pref_ok || fine_found) && !busy;
            flush_req   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
            owner  <= '0;
        end else if (mode == SEL_FINE) begin
            if (issue_valid) begin
                rr_ptr <= TID_W'(wrap_inc(int'(issue_tid), NUM_THREADS));
                owner  <= issue_tid;
            end
        end else if (flush_req) begin
            owner <= sw_tid;
        end
    end

    // R2: anything issued must be eligible
    a_r2_valid_eligible: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> elig[issue_tid]);

    // R4: idle threads give no issue and freeze the pointer
    a_r4_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        (elig == '0) |-> !issue_valid);
    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (elig == '0) |=> $stable(rr_ptr));

    // R6: coarse owner only moves with a flush
    a_r6_owner_stable: assert property (@(posedge clk) disable iff (rst)
        (mode_coarse && !flush_req) |=> $stable(owner));

    // R7 / R10: flush only for a coarse long stall
    a_r7_flush_cause: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> (mode_coarse && long_stall));

    // R8: issue suppressed right after a switch
    a_r8_refill_gap: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> !issue_valid);
endmodule

// File: tb/mt_issue_sel_tb.sv
`timescale 1ns/1ps
module mt_issue_sel_tb;
    localparam int N  = 4;
    localparam int RF = 3;

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0] thr_ready, thr_stall;
    logic long_stall, mode_coarse, pref_en;
    logic [1:0] pref_tid, issue_tid;
    logic issue_valid, flush_req;

    int tests = 0;
    int fails = 0;

    int m_ptr, m_own, m_cnt;
    int e_tid, e_sw;
    bit e_v, e_f;

    always #4 clk = ~clk;

    mt_issue_sel #(.NUM_THREADS(N), .REFILL_CYCLES(RF)) u_dut (
        .clk(clk), .rst(rst), .thr_ready(thr_ready), .thr_stall(thr_stall),
        .long_stall(long_stall), .mode_coarse(mode_coarse), .pref_en(pref_en),
        .pref_tid(pref_tid), .issue_tid(issue_tid), .issue_valid(issue_valid),
        .flush_req(flush_req)
    );

    function automatic int first_from(logic [N-1:0] m, int s);
        for (int k = 0; k < N; k++)
            if (m[(s + k) % N]) return (s + k) % N;
        return -1;
    endfunction

    // expected outputs from the requirement rules
    function automatic string model_out();
        logic [N-1:0] el, oth;
        bit pok;
        int f;
        el  = thr_ready & ~thr_stall;
        pok = pref_en && el[pref_tid];
        e_sw = -1;
        if (mode_coarse) begin
            oth = el; oth[m_own] = 1'b0;
            if (pok && int'(pref_tid) != m_own) e_sw = int'(pref_tid);
            else e_sw = first_from(oth, (m_own + 1) % N);
            e_tid = m_own;
            e_f   = long_stall && (e_sw >= 0);
            e_v   = el[m_own] && !long_stall && (m_cnt == 0);
            if (e_f) return "R7";
            if (long_stall) return "R9";
            if (m_cnt > 0) return "R8";
            return "R6";
        end
        f     = first_from(el, m_ptr);
        e_tid = pok ? int'(pref_tid) : f;
        e_f   = 1'b0;
        e_v   = (pok || f >= 0) && (m_cnt == 0);
        if (m_cnt > 0) return "R8";
        if (el == '0) return "R4";
        if (long_stall) return "R10";
        if (pok) return "R5";
        return "R2";
    endfunction

    task automatic check(string tag);
        tests++;
        if (issue_valid !== e_v || flush_req !== e_f ||
            (e_v && int'(issue_tid) != e_tid)) begin
            fails++;
            $display("FAIL %s: got tid=%0d v=%0b f=%0b exp tid=%0d v=%0b f=%0b",
                     tag, issue_tid, issue_valid, flush_req, e_tid, e_v, e_f);
        end
    endtask

    task automatic step(logic [N-1:0] rdy, logic [N-1:0] stl, bit ls, bit mc,
                        bit pe, logic [1:0] pt, string tag);
        string t;
        @(negedge clk);
        thr_ready = rdy; thr_stall = stl; long_stall = ls;
        mode_coarse = mc; pref_en = pe; pref_tid = pt;
        #1;
        t = model_out();
        check((tag == "") ? t : tag);
        @(posedge clk);
        if (m_cnt > 0) m_cnt--;
        if (!mc) begin
            if (e_v) begin m_ptr = (e_tid + 1) % N; m_own = e_tid; end
        end else if (e_f) begin
            m_own = e_sw; m_cnt = RF;
        end
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        thr_ready = '0; thr_stall = '0; long_stall = 0;
        mode_coarse = 0; pref_en = 0; pref_tid = '0;
        m_ptr = 0; m_own = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        step(4'hF, 4'h0, 0, 0, 0, 0, "R1");        // thread 0 first
        step(4'hF, 4'h0, 0, 0, 0, 0, "R3");        // then thread 1
        step(4'hF, 4'b0100, 0, 0, 0, 0, "R2");     // skip stalled 2 -> 3
        step(4'b0001, 4'h0, 0, 0, 0, 0, "R2");     // wrap to 0
        step(4'h0, 4'h0, 0, 0, 0, 0, "R4");        // idle
        step(4'hF, 4'h0, 0, 0, 0, 0, "R4");        // pointer held -> 1
        step(4'hF, 4'h0, 1, 0, 1, 2'd3, "R10");    // long stall ignored, pref 3
        step(4'hF, 4'b1000, 0, 0, 1, 2'd3, "R5");  // pref stalled, rotate
        step(4'hF, 4'h0, 0, 1, 0, 0, "R6");        // coarse owner kept
        step(4'b0001, 4'h0, 1, 1, 0, 0, "R9");     // nobody else eligible
        step(4'hF, 4'h0, 1, 1, 0, 0, "R7");        // switch
        for (int i = 0; i < RF + 1; i++)
            step(4'hF, 4'h0, 0, 1, 0, 0, "R8");

        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] r, s;
            bit ls, mc, pe;
            r  = N'($urandom);
            s  = N'($urandom) & N'($urandom);
            ls = ($urandom % 6) == 0;
            mc = ((i / 200) % 2) == 1;
            pe = ($urandom % 4) == 0;
            step(r, s, ls, mc, pe, 2'($urandom), "");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule